// File: doc/BRIEF.md
# Sample Clock Phase Tuning Controller

This block searches for a usable receive sampling phase on a high-speed card bus. After a start request it puts the sampling delay line into its tuning mode. It then walks the sample-clock phase selector through eight candidates, 0 to 315 degrees in 45-degree steps, always upward from index 0. For each candidate it drives the phase, pulses a status-clear strobe, and raises a tuning-transfer request. It waits for a done reply or a timeout, then judges the step.

A step fails when the transfer reports an error, when the sampler's edge-detected flag is high the cycle after the reply, or when the reply never comes. The controller records where a passing window opens and where it closes. It stops sweeping as soon as both are known, leaves tuning mode, and pulses one final status clear. It then applies the centre of the window to the phase output, or raises a fail flag if no candidate passed. The result is reported with a one-cycle done pulse.

Top module: `phase_tune_ctrl`

## Requirements
- R1: After synchronous reset, dll_mode_o is 1 and xfer_req_o, clr_status_o, tune_done_o and tune_fail_o are 0, with phase_sel_o and sel_idx_o at index 0.
- R2: dll_mode_o drops to 0 on the clock edge that accepts start_i. It stays 0 for the whole sweep and returns to 1 on the same edge that raises tune_done_o.
- R3: Each tuning transfer is made at one candidate index. The first uses index 0 and each later one uses the next index up. phase_sel_o holds that index for as long as xfer_req_o is high.
- R4: clr_status_o pulses for one cycle before every transfer request, and once more together with tune_done_o. Across a sweep of N steps it therefore pulses N+1 times.
- R5: A step fails if xfer_err_i is high with xfer_done_i, if edge_flag_i is high in the cycle after xfer_done_i is accepted, or if the transfer times out.
- R6: The previous result starts as failed. A pass after a fail marks the rising index, and a fail after a pass marks the falling index. The sweep ends once both are known, or after index 7.
- R7: A missing rising index counts as 0 and a missing falling index counts as 7. If falling >= rising, the chosen index is (rising+falling)/2. Otherwise it is falling/2 when rising+falling > 7, and (rising+7)/2 in the remaining case.
- R8: If no step passed, tune_fail_o is 1 with the done pulse, and phase_sel_o and sel_idx_o go back to the phase held before the sweep. Otherwise tune_fail_o is 0 and both carry the chosen index.
- R9: Without xfer_done_i, xfer_req_o stays high for exactly timeout_i+1 cycles, using the timeout_i value captured at start, and then falls.
- R10: tune_done_o is a one-cycle pulse. A start_i seen while a sweep runs is ignored: no extra transfer follows the done pulse.
- R11: xfer_opcode_o carries the opcode_i value captured at start for every transfer of that sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a tuning sweep (ignored while busy) |
| opcode_i | input | 6 | Command code used for the tuning transfers |
| timeout_i | input | 16 | Transfer timeout, in cycles, captured at start |
| phase_sel_o | output | 3 | Sample-clock phase index (45 degrees per step) |
| clr_status_o | output | 1 | One-cycle strobe: clear all raw status flags |
| xfer_req_o | output | 1 | Tuning-transfer request, held until done or timeout |
| xfer_opcode_o | output | 6 | Command code for the tuning transfer |
| xfer_done_i | input | 1 | Tuning transfer finished |
| xfer_err_i | input | 1 | Transfer error, valid with xfer_done_i |
| edge_flag_i | input | 1 | Sampler edge-found flag, read the cycle after done |
| dll_mode_o | output | 1 | Delay-line mode: 0 while tuning, 1 otherwise |
| tune_done_o | output | 1 | One-cycle sweep-finished pulse |
| tune_fail_o | output | 1 | No passing phase found (valid with done) |
| sel_idx_o | output | 3 | Selected phase index |

## Verification
The assertions take for granted that xfer_done_i pulses for one cycle and only while xfer_req_o is high. They also assume edge_flag_i is already settled in the cycle after that reply. The bench's responder follows these rules. It answers each request after a chosen delay no longer than the timeout, or not at all for steps meant to time out. It drives the edge flag together with the reply and holds it until the next reply. The stimulus places windows at the start, middle and end of the sweep, and it also covers a sweep with no passing phase, edge-flag and timeout failures, and a start pulse injected mid-sweep.

// File: rtl/phase_tune_pkg.sv
package phase_tune_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PHASE,
    ST_CLEAR,
    ST_ISSUE,
    ST_WAIT,
    ST_EVAL,
    ST_FINISH
  } tune_state_e;
endpackage

// File: rtl/tune_xfer_timer.sv
module tune_xfer_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else if (cnt_q != limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == limit_i);

  assert_timer_bound_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= limit_i);
endmodule

// File: rtl/tune_window_track.sv
module tune_window_track #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             eval_i,
  input  logic             fail_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             rise_v_o,
  output logic [IDX_W-1:0] rise_o,
  output logic             fall_v_o,
  output logic [IDX_W-1:0] fall_o,
  output logic             any_pass_o,
  output logic             stop_now_o
);
  logic prev_fail_q;
  logic rise_hit, fall_hit;

  assign rise_hit   = eval_i && !fail_i && prev_fail_q;
  assign fall_hit   = eval_i && fail_i && !prev_fail_q;
  assign stop_now_o = (rise_v_o || rise_hit) && (fall_v_o || fall_hit);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      prev_fail_q <= 1'b1;
      rise_v_o    <= 1'b0;
      fall_v_o    <= 1'b0;
      rise_o      <= '0;
      fall_o      <= '0;
      any_pass_o  <= 1'b0;
    end else if (eval_i) begin
      prev_fail_q <= fail_i;
      if (!fail_i) any_pass_o <= 1'b1;
      if (rise_hit) begin
        rise_v_o <= 1'b1;
        rise_o   <= idx_i;
      end
      if (fall_hit) begin
        fall_v_o <= 1'b1;
        fall_o   <= idx_i;
      end
    end
  end

  // a fall needs an earlier pass, and any pass after the initial fail marks a rise
  assert_fall_after_rise_R6: assert property (@(posedge clk) disable iff (rst)
    fall_v_o |-> rise_v_o);
  assert_pass_has_rise_R6: assert property (@(posedge clk) disable iff (rst)
    any_pass_o |-> rise_v_o);
endmodule

// File: rtl/tune_mid_pick.sv
module tune_mid_pick #(
  parameter int N_PHASE = 8,
  parameter int IDX_W   = 3
) (
  input  logic             rise_v_i,
  input  logic [IDX_W-1:0] rise_i,
  input  logic             fall_v_i,
  input  logic [IDX_W-1:0] fall_i,
  output logic [IDX_W-1:0] mid_o
);
  localparam logic [IDX_W:0] LAST = (IDX_W+1)'(N_PHASE - 1);

  logic [IDX_W:0] r, f, sum_rf, sum_rl, m;

  always_comb begin
    r      = rise_v_i ? {1'b0, rise_i} : '0;
    f      = fall_v_i ? {1'b0, fall_i} : LAST;
    sum_rf = r + f;
    sum_rl = r + LAST;
    if (f < r) begin
      if (sum_rf > LAST) m = f >> 1;
      else               m = sum_rl >> 1;
    end else begin
      m = sum_rf >> 1;
    end
    mid_o = m[IDX_W-1:0];
  end
endmodule

// File: rtl/phase_tune_ctrl.sv
module phase_tune_ctrl
  import phase_tune_pkg::*;
#(
  parameter int N_PHASE = 8,
  parameter int OPC_W   = 6,
  parameter int TMO_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start_i,
  input  logic [OPC_W-1:0]             opcode_i,
  input  logic [TMO_W-1:0]             timeout_i,
  output logic [$clog2(N_PHASE)-1:0]   phase_sel_o,
  output logic                         clr_status_o,
  output logic                         xfer_req_o,
  output logic [OPC_W-1:0]             xfer_opcode_o,
  input  logic                         xfer_done_i,
  input  logic                         xfer_err_i,
  input  logic                         edge_flag_i,
  output logic                         dll_mode_o,
  output logic                         tune_done_o,
  output logic                         tune_fail_o,
  output logic [$clog2(N_PHASE)-1:0]   sel_idx_o
);
  localparam int IDX_W = $clog2(N_PHASE);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_PHASE - 1);

  tune_state_e      state_q;
  logic [IDX_W-1:0] idx_q, saved_q, mid;
  logic [TMO_W-1:0] tmo_q;
  logic             xfer_fail_q, expired;
  logic             rise_v, fall_v, any_pass, stop_now;
  logic [IDX_W-1:0] rise, fall;
  logic             step_fail, eval, clear_track;

  assign eval        = (state_q == ST_EVAL);
  assign step_fail   = xfer_fail_q || edge_flag_i;
  assign clear_track = (state_q == ST_IDLE) && start_i;

  tune_xfer_timer #(.TMO_W(TMO_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run_i    (state_q == ST_WAIT),
    .limit_i  (tmo_q),
    .expired_o(expired)
  );

  tune_window_track #(.IDX_W(IDX_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (clear_track),
    .eval_i    (eval),
    .fail_i    (step_fail),
    .idx_i     (idx_q),
    .rise_v_o  (rise_v),
    .rise_o    (rise),
    .fall_v_o  (fall_v),
    .fall_o    (fall),
    .any_pass_o(any_pass),
    .stop_now_o(stop_now)
  );

  tune_mid_pick #(.N_PHASE(N_PHASE), .IDX_W(IDX_W)) u_mid (
    .rise_v_i(rise_v),
    .rise_i  (rise),
    .fall_v_i(fall_v),
    .fall_i  (fall),
    .mid_o   (mid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      idx_q         <= '0;
      saved_q       <= '0;
      tmo_q         <= '0;
      xfer_fail_q   <= 1'b0;
      phase_sel_o   <= '0;
      clr_status_o  <= 1'b0;
      xfer_req_o    <= 1'b0;
      xfer_opcode_o <= '0;
      dll_mode_o    <= 1'b1;
      tune_done_o   <= 1'b0;
      tune_fail_o   <= 1'b0;
      sel_idx_o     <= '0;
    end else begin
      clr_status_o <= 1'b0;
      tune_done_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          idx_q         <= '0;
          saved_q       <= phase_sel_o;
          tmo_q         <= timeout_i;
          xfer_opcode_o <= opcode_i;
          dll_mode_o    <= 1'b0;
          state_q       <= ST_PHASE;
        end
        ST_PHASE: begin
          phase_sel_o <= idx_q;
          state_q     <= ST_CLEAR;
        end
        ST_CLEAR: begin
          clr_status_o <= 1'b1;
          state_q      <= ST_ISSUE;
        end
        ST_ISSUE: begin
          xfer_req_o <= 1'b1;
          state_q    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (xfer_done_i) begin
            xfer_req_o  <= 1'b0;
            xfer_fail_q <= xfer_err_i;
            state_q     <= ST_EVAL;
          end else if (expired) begin
            xfer_req_o  <= 1'b0;
            xfer_fail_q <= 1'b1;
            state_q     <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (stop_now || idx_q == LAST_IDX) begin
            state_q <= ST_FINISH;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_PHASE;
          end
        end
        ST_FINISH: begin
          dll_mode_o   <= 1'b1;
          clr_status_o <= 1'b1;
          tune_done_o  <= 1'b1;
          tune_fail_o  <= !any_pass;
          phase_sel_o  <= any_pass ? mid : saved_q;
          sel_idx_o    <= any_pass ? mid : saved_q;
          state_q      <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_req_in_tuning_R2: assert property (@(posedge clk) disable iff (rst)
    xfer_req_o |-> !dll_mode_o);
  assert_done_leaves_tuning_R2: assert property (@(posedge clk) disable iff (rst)
    tune_done_o |-> dll_mode_o);
  assert_phase_held_R3: assert property (@(posedge clk) disable iff (rst)
    (xfer_req_o && $past(xfer_req_o)) |-> $stable(phase_sel_o));
  assert_clear_apart_R4: assert property (@(posedge clk) disable iff (rst)
    clr_status_o |-> !xfer_req_o);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    tune_done_o |=> !tune_done_o);
  assert_opcode_held_R11: assert property (@(posedge clk) disable iff (rst)
    (xfer_req_o && $past(xfer_req_o)) |-> $stable(xfer_opcode_o));
endmodule

// File: tb/phase_tune_ctrl_bench.sv
module phase_tune_ctrl_bench;
  localparam int TMO = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [5:0] opcode_i = '0;
  logic [15:0] timeout_i = 16'(TMO);
  logic [2:0] phase_sel_o, sel_idx_o;
  logic       clr_status_o, xfer_req_o, dll_mode_o, tune_done_o, tune_fail_o;
  logic [5:0] xfer_opcode_o;
  logic       xfer_done_i = 1'b0, xfer_err_i = 1'b0, edge_flag_i = 1'b0;

  int vectors = 0;
  int errors  = 0;
  int last_phase = 0;

  always #2.5 clk = ~clk;

  phase_tune_ctrl u_phase_tune_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .opcode_i(opcode_i),
    .timeout_i(timeout_i), .phase_sel_o(phase_sel_o), .clr_status_o(clr_status_o),
    .xfer_req_o(xfer_req_o), .xfer_opcode_o(xfer_opcode_o), .xfer_done_i(xfer_done_i),
    .xfer_err_i(xfer_err_i), .edge_flag_i(edge_flag_i), .dll_mode_o(dll_mode_o),
    .tune_done_o(tune_done_o), .tune_fail_o(tune_fail_o), .sel_idx_o(sel_idx_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pick_mid(input int r, input int f);
    if (r < 0) r = 0;
    if (f < 0) f = 7;
    if (f < r) return (r + f > 7) ? f / 2 : (r + 7) / 2;
    return (r + f) / 2;
  endfunction

  // pass: transfer answers without error; edg: edge flag raised; tmo: no answer
  task automatic run(input logic [7:0] pass, input logic [7:0] edg,
                     input logic [7:0] tmo, input int dly, input logic [5:0] opc,
                     input bit poke);
    int rise = -1, fall = -1, nsteps = 0, prev_fail = 1;
    int exp_sel, steps = 0, clears = 0, mode = 0, cnt = 0, cyc = 0;
    bit exp_fail, poked = 0;
    for (int i = 0; i < 8; i++) begin
      int f = (!pass[i] || edg[i] || tmo[i]) ? 1 : 0;
      nsteps++;
      if (!f && prev_fail) rise = i;
      if (f && !prev_fail) fall = i;
      prev_fail = f;
      if (rise != -1 && fall != -1) break;
    end
    exp_fail = (rise == -1);
    exp_sel  = exp_fail ? last_phase : pick_mid(rise, fall);

    @(negedge clk);
    opcode_i = opc;
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
    chk(dll_mode_o == 1'b0, "R2 tuning mode entered", dll_mode_o, 0);
    forever begin
      if (clr_status_o) clears++;
      if (tune_done_o) break;
      chk(dll_mode_o == 1'b0, "R2 mode held low", dll_mode_o, 0);
      if (poke && poked && start_i) start_i = 1'b0;
      case (mode)
        0: if (xfer_req_o) begin
          steps++;
          chk(phase_sel_o == 3'(steps - 1), "R3 ascending phase", phase_sel_o, steps - 1);
          chk(clears == steps, "R4 clear before request", clears, steps);
          chk(xfer_opcode_o == opc, "R11 opcode", xfer_opcode_o, opc);
          if (poke && steps == 3 && !poked) begin start_i = 1'b1; poked = 1; end
          if (tmo[steps-1]) begin mode = 2; cnt = 1; end
          else begin mode = 1; cnt = dly; end
        end
        1: begin
          chk(xfer_req_o == 1'b1 && phase_sel_o == 3'(steps - 1), "R3 phase held",
              phase_sel_o, steps - 1);
          if (cnt == 0) begin
            xfer_done_i = 1'b1;
            xfer_err_i  = !pass[steps-1];
            edge_flag_i = edg[steps-1];
            mode = 3;
          end else cnt--;
        end
        2: if (xfer_req_o) cnt++;
           else begin
             chk(cnt == TMO + 1, "R9 timeout length", cnt, TMO + 1);
             mode = 0;
           end
        default: begin
          xfer_done_i = 1'b0;
          xfer_err_i  = 1'b0;
          mode = 0;
        end
      endcase
      cyc++;
      if (cyc > 400) begin
        chk(0, "R10 watchdog done", 0, 1);
        break;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(dll_mode_o == 1'b1, "R2 tuning mode left", dll_mode_o, 1);
    chk(steps == nsteps, "R6 step count", steps, nsteps);
    chk(clears == nsteps + 1, "R4 clear count", clears, nsteps + 1);
    chk(tune_fail_o == exp_fail, "R8 fail flag", tune_fail_o, exp_fail);
    chk(sel_idx_o == 3'(exp_sel), "R7 selected index", sel_idx_o, exp_sel);
    chk(phase_sel_o == 3'(exp_sel), "R8 phase output", phase_sel_o, exp_sel);
    last_phase = exp_sel;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!tune_done_o && !xfer_req_o && dll_mode_o, "R10 quiet after done",
          {tune_done_o, xfer_req_o, dll_mode_o}, 1);
    end
    edge_flag_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(dll_mode_o == 1'b1, "R1 reset mode", dll_mode_o, 1);
    chk(!xfer_req_o && !clr_status_o && !tune_done_o && !tune_fail_o, "R1 reset flags",
        {xfer_req_o, clr_status_o, tune_done_o, tune_fail_o}, 0);
    chk(phase_sel_o == 0 && sel_idx_o == 0, "R1 reset phase", phase_sel_o, 0);
    run(8'hFF, 8'h00, 8'h00, 0, 6'd19, 0);  // R7 window to the end: mid 3
    run(8'h3C, 8'h00, 8'h00, 2, 6'd21, 0);  // R6 window 2..6: mid 4
    run(8'h00, 8'h00, 8'h00, 1, 6'd19, 0);  // R8 nothing passes, phase kept
    run(8'h01, 8'h00, 8'h00, 3, 6'd21, 0);  // R6 only index 0: mid 0
    run(8'hFF, 8'h18, 8'h00, 1, 6'd19, 0);  // R5 edge flag fails step 3: mid 1
    run(8'hFF, 8'h00, 8'hF0, 0, 6'd19, 0);  // R5 R9 timeouts from 4: mid 2
    run(8'hE0, 8'h00, 8'h00, 1, 6'd21, 1);  // R10 start poked mid sweep: mid 6
    run(8'h80, 8'h00, 8'h00, 2, 6'd19, 0);  // R7 only index 7: mid 7
    run(8'h00, 8'hFF, 8'h00, 0, 6'd19, 0);  // R8 all edge failures
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL R10 watchdog expired: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule